// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block is the configuration front end of a receiver: an external controller drives three lines (a serial clock, an active-low framing enable and a data line), and the block turns the serial frames into writes of seven 12-bit control registers. The registers drive the rest of the chip in parallel on `cfg_bus`. A separate multi-function output pin, whose role is picked by a 4-bit field of register 3, can return the contents of any register, including a read-only status word presented at address 7.

The three serial lines are asynchronous to the chip clock. Each is brought through a synchronizer and its edges are found in the chip clock domain. A frame opens when the enable line falls. Data is taken on each rising serial clock, the first bit being the read/write flag, then address bits A0..A2, then data D0..D11. When the enable line rises, the frame is decoded. A write updates one register. A read loads the addressed word into an output shifter, and the bits then leave on the multi-function pin MSB first, one per falling serial clock.

The frame state machine has three states. IDLE waits for the enable line to fall (IDLE to SHIFT). SHIFT collects bits; on the enable rise it returns to IDLE for a write (SHIFT to IDLE) or goes to SEND for a read (SHIFT to SEND). SEND presents readback bits. It returns to IDLE after the twelfth falling serial clock (SEND to IDLE), or goes back to SHIFT if a new frame starts early (SEND to SHIFT).

Top module: `tri_wire_cfg_port`

## Requirements
- R1: After reset, registers 0..6 hold 0xB88, 0x8B4, 0xEEC, 0x400, 0x04B, 0x29B and 0xA6C. Register i sits at `cfg_bus[i*12 +: 12]`.
- R2: A 16-bit frame with first bit 0 (write) and address A (bits 1..3, A0 first) loads bits 4..15 (D0 first) into register A when the enable line rises. Every other register keeps its value.
- R3: When more than 16 bits are shifted in one frame, only the last 16 are used; the earlier bits are discarded.
- R4: A write to address 7 changes no register.
- R5: A frame of exactly 4 bits whose first bit is 1 is a read of the address in its last three bits. Once the enable line has risen, the pin shows D11 of that register. Each falling serial clock then advances the pin to the next lower bit, down to D0.
- R6: A read of address 7 returns the `stat_word` input.
- R7: The pin function code is bits 11:8 of register 3. Code 0000, and any undefined code, leaves the pin undriven (`mfo_oe`=0, `mfo_out`=0). Code 0010 drives 0, 0011 drives 1 and 1000 drives `lock_flag`.
- R8: Readback bits reach the pin only under code 0001. Under that code the pin drives 0 when no readback is in progress.
- R9: A frame of fewer than 16 bits that is not a 4-bit read is decoded from the shift register contents as they stand. The shift register is not cleared between frames, so the new bits sit at the top and older bits fill the rest.
- R10: After the twelfth falling serial clock of a readback, the readback ends and the pin returns to its idle value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_en | input | 1 | Frame enable, low during shifting, rising edge commits |
| ser_din | input | 1 | Serial data |
| lock_flag | input | 1 | Lock indication routed to the pin under code 1000 |
| stat_word | input | 12 | Read-only status word at address 7 |
| cfg_bus | output | 84 | Registers 0..6, register i at bits i*12 +: 12 |
| mfo_out | output | 1 | Multi-function pin value |
| mfo_oe | output | 1 | Multi-function pin drive enable |

## Verification
The bench uses the default parameters: 12 data bits, 3 address bits and two synchronizer stages. This gives seven writable registers plus the status address, a 16-bit write word and a 4-bit read frame. With these values every register and the address-7 corner can be reached, along with the exact 4-bit read count and the saturation of the bit count at 16 when leading junk bits are sent. The short-frame case is predicted by a bench-side model of the 16-bit shift register that persists across frames.

// File: rtl/twc_pkg.sv
package twc_pkg;
    localparam int CFG_DATA_W   = 12;
    localparam int CFG_ADDR_W   = 3;
    localparam int PIN_CODE_REG = 3;
    localparam int PIN_CODE_LSB = 8;
    localparam int PIN_CODE_W   = 4;

    typedef enum logic [3:0] {
        PIN_FLOAT    = 4'b0000,
        PIN_READBACK = 4'b0001,
        PIN_LOW      = 4'b0010,
        PIN_HIGH     = 4'b0011,
        PIN_LOCK     = 4'b1000
    } pin_fn_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_SEND
    } frame_st_e;

    function automatic logic [CFG_DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 12'hB88;
            1:       return 12'h8B4;
            2:       return 12'hEEC;
            3:       return 12'h400;
            4:       return 12'h04B;
            5:       return 12'h29B;
            6:       return 12'hA6C;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/twc_sync.sv
module twc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/twc_frame_fsm.sv
module twc_frame_fsm
    import twc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sen_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              send_active,
    output logic              send_bit
);
    localparam int WORD_W = 1 + ADDR_W + DATA_W;
    localparam int RD_LEN = 1 + ADDR_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int LEFT_W = $clog2(DATA_W + 1);

    frame_st_e         state, state_nx;
    logic              sclk_d, sen_d;
    logic              clk_rise, clk_fall, en_rise, en_fall;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] out_sr;
    logic [LEFT_W-1:0] bits_left;
    logic              short_read, is_read;

    // edge detection in the chip clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sen_d  <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            sen_d  <= sen_s;
        end
    end

    assign clk_rise = sclk_s & ~sclk_d;
    assign clk_fall = ~sclk_s & sclk_d;
    assign en_rise  = sen_s & ~sen_d;
    assign en_fall  = ~sen_s & sen_d;

    // frame decode
    assign short_read = (bit_cnt == CNT_W'(RD_LEN)) && shreg[WORD_W-RD_LEN];
    assign is_read    = short_read || shreg[0];
    assign rd_addr    = short_read ? shreg[WORD_W-1 -: ADDR_W] : shreg[ADDR_W:1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (en_fall) state_nx = ST_SHIFT;
            ST_SHIFT: if (en_rise) state_nx = is_read ? ST_SEND : ST_IDLE;
            ST_SEND: begin
                if (en_fall)
                    state_nx = ST_SHIFT;
                else if (clk_fall && bits_left == LEFT_W'(1))
                    state_nx = ST_IDLE;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bit_cnt   <= '0;
            out_sr    <= '0;
            bits_left <= '0;
            wr_pulse  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
        end else begin
            wr_pulse <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (en_fall) bit_cnt <= '0;
                end
                ST_SHIFT: begin
                    if (clk_rise && !en_rise) begin
                        shreg <= {sdi_s, shreg[WORD_W-1:1]};
                        if (bit_cnt != CNT_W'(WORD_W)) bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (en_rise) begin
                        if (is_read) begin
                            out_sr    <= rd_word;
                            bits_left <= LEFT_W'(DATA_W);
                        end else begin
                            wr_pulse <= 1'b1;
                            wr_addr  <= shreg[ADDR_W:1];
                            wr_data  <= shreg[WORD_W-1 -: DATA_W];
                        end
                    end
                end
                ST_SEND: begin
                    if (en_fall) begin
                        bit_cnt   <= '0;
                        bits_left <= '0;
                    end else if (clk_fall) begin
                        out_sr    <= {out_sr[DATA_W-2:0], 1'b0};
                        bits_left <= bits_left - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign send_active = (state == ST_SEND);
    assign send_bit    = out_sr[DATA_W-1];
endmodule

// File: rtl/twc_reg_bank.sv
module twc_reg_bank
    import twc_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int ADDR_W = 3,
    localparam int NUM_REGS = (1 << ADDR_W) - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_pulse,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [DATA_W-1:0]          stat_word,
    output logic [DATA_W-1:0]          rd_word,
    output logic [NUM_REGS-1:0]        wr_en,
    output logic [NUM_REGS*DATA_W-1:0] cfg_bus
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        assign wr_en[i] = wr_pulse && (wr_addr == ADDR_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      regs[i] <= DATA_W'(reg_default(i));
            else if (wr_en[i]) regs[i] <= wr_data;
        end

        assign cfg_bus[i*DATA_W +: DATA_W] = regs[i];
    end

    // the top address holds the read-only status word
    always_comb begin
        rd_word = stat_word;
        for (int j = 0; j < NUM_REGS; j++) begin
            if (rd_addr == ADDR_W'(j)) rd_word = regs[j];
        end
    end
endmodule

// File: rtl/twc_pin_mux.sv
module twc_pin_mux
    import twc_pkg::*;
(
    input  logic [PIN_CODE_W-1:0] pin_code,
    input  logic                  send_active,
    input  logic                  send_bit,
    input  logic                  lock_flag,
    output logic                  mfo_out,
    output logic                  mfo_oe
);
    always_comb begin
        mfo_out = 1'b0;
        mfo_oe  = 1'b0;
        unique case (pin_code)
            PIN_READBACK: begin
                mfo_oe  = 1'b1;
                mfo_out = send_active & send_bit;
            end
            PIN_LOW:  mfo_oe = 1'b1;
            PIN_HIGH: begin
                mfo_oe  = 1'b1;
                mfo_out = 1'b1;
            end
            PIN_LOCK: begin
                mfo_oe  = 1'b1;
                mfo_out = lock_flag;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tri_wire_cfg_port.sv
module tri_wire_cfg_port
    import twc_pkg::*;
#(
    parameter int DATA_W      = CFG_DATA_W,
    parameter int ADDR_W      = CFG_ADDR_W,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_REGS   = (1 << ADDR_W) - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_clk,
    input  logic                       ser_en,
    input  logic                       ser_din,
    input  logic                       lock_flag,
    input  logic [DATA_W-1:0]          stat_word,
    output logic [NUM_REGS*DATA_W-1:0] cfg_bus,
    output logic                       mfo_out,
    output logic                       mfo_oe
);
    logic                  sclk_s, sen_s, sdi_s;
    logic [ADDR_W-1:0]     rd_addr, wr_addr;
    logic [DATA_W-1:0]     rd_word, wr_data;
    logic                  wr_pulse, send_active, send_bit;
    logic [NUM_REGS-1:0]   wr_en;
    logic [PIN_CODE_W-1:0] pin_code;

    twc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .async_in(ser_clk), .sync_out(sclk_s));
    twc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_en (
        .clk(clk), .rst_n(rst_n), .async_in(ser_en), .sync_out(sen_s));
    twc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .async_in(ser_din), .sync_out(sdi_s));

    twc_frame_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(sclk_s), .sen_s(sen_s), .sdi_s(sdi_s),
        .rd_word(rd_word), .rd_addr(rd_addr),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
        .send_active(send_active), .send_bit(send_bit));

    twc_reg_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .stat_word(stat_word), .rd_word(rd_word),
        .wr_en(wr_en), .cfg_bus(cfg_bus));

    assign pin_code = cfg_bus[PIN_CODE_REG*DATA_W + PIN_CODE_LSB +: PIN_CODE_W];

    twc_pin_mux u_pin (
        .pin_code(pin_code), .send_active(send_active), .send_bit(send_bit),
        .lock_flag(lock_flag), .mfo_out(mfo_out), .mfo_oe(mfo_oe));
endmodule

// File: rtl/tri_wire_cfg_port_chk.sv
module tri_wire_cfg_port_chk
    import twc_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int ADDR_W   = 3,
    parameter int NUM_REGS = 7
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_pulse,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [NUM_REGS-1:0]        wr_en,
    input logic [PIN_CODE_W-1:0]      pin_code,
    input logic                       send_active,
    input logic                       mfo_out,
    input logic                       mfo_oe,
    input logic [NUM_REGS*DATA_W-1:0] cfg_bus
);
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en)); // R2

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> $stable(cfg_bus)); // R2

    AST_TOP_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_addr == '1) |=> $stable(cfg_bus)); // R4

    AST_FLOAT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_code == PIN_FLOAT) |-> (!mfo_oe && !mfo_out)); // R7

    AST_HIGH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_code == PIN_HIGH) |-> (mfo_oe && mfo_out)); // R7

    AST_READBACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_code == PIN_READBACK && !send_active) |-> (mfo_oe && !mfo_out)); // R8
endmodule

bind tri_wire_cfg_port tri_wire_cfg_port_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(wr_addr),
    .wr_en(wr_en), .pin_code(pin_code), .send_active(send_active),
    .mfo_out(mfo_out), .mfo_oe(mfo_oe), .cfg_bus(cfg_bus)
);

// File: tb/tri_wire_cfg_port_test.sv
module tri_wire_cfg_port_test;
    localparam int DW = 12;
    localparam int NR = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_clk = 1'b0;
    logic          ser_en = 1'b1;
    logic          ser_din = 1'b0;
    logic          lock_flag = 1'b0;
    logic [DW-1:0] stat_word = 12'h5A3;
    logic [NR*DW-1:0] cfg_bus;
    logic          mfo_out, mfo_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [15:0]   m_sr = '0;
    logic [DW-1:0] m_regs [NR];

    tri_wire_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
        .ser_din(ser_din), .lock_flag(lock_flag), .stat_word(stat_word),
        .cfg_bus(cfg_bus), .mfo_out(mfo_out), .mfo_oe(mfo_oe));

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NR; i++)
            check(req, 32'(cfg_bus[i*DW +: DW]), 32'(m_regs[i]));
    endtask

    task automatic send_frame(input logic [31:0] bits, input int n);
        ser_en = 1'b0;
        tick(4);
        for (int i = 0; i < n; i++) begin
            ser_din = bits[i];
            tick(4);
            ser_clk = 1'b1;
            m_sr = {bits[i], m_sr[15:1]};
            tick(4);
            ser_clk = 1'b0;
        end
        tick(4);
        ser_en = 1'b1;
        tick(8);
    endtask

    task automatic write_reg(input logic [2:0] addr, input logic [DW-1:0] data);
        send_frame(32'({data, addr, 1'b0}), 16);
        if (addr != 3'd7) m_regs[addr] = data;
    endtask

    // 4-bit read, then collect 12 bits MSB first and compare
    task automatic read_check(input string req, input logic [2:0] addr, input logic [DW-1:0] exp);
        logic [DW-1:0] got;
        send_frame(32'({addr, 1'b1}), 4);
        check(req, 32'(mfo_oe), 32'd1);
        got[DW-1] = mfo_out;
        for (int k = 1; k < DW; k++) begin
            ser_clk = 1'b1;
            tick(4);
            ser_clk = 1'b0;
            tick(8);
            got[DW-1-k] = mfo_out;
        end
        check(req, 32'(got), 32'(exp));
        ser_clk = 1'b1;
        tick(4);
        ser_clk = 1'b0;
        tick(8);
    endtask

    task automatic t_reset;
        check_regs("R1 reset defaults");
        check("R7 code 0100 undriven oe", 32'(mfo_oe), 32'd0);
        check("R7 code 0100 undriven out", 32'(mfo_out), 32'd0);
    endtask

    task automatic t_write;
        write_reg(3'd3, 12'h1C3);
        check_regs("R2 write reg3");
        check("R8 idle readback pin low", 32'({mfo_oe, mfo_out}), 32'b10);
        write_reg(3'd0, 12'h123);
        check_regs("R2 write reg0");
        write_reg(3'd6, 12'hFA5);
        check_regs("R2 write reg6");
    endtask

    task automatic t_read;
        read_check("R5 read reg0", 3'd0, 12'h123);
        check("R10 pin idle after readback", 32'({mfo_oe, mfo_out}), 32'b10);
        read_check("R5 read reg6", 3'd6, 12'hFA5);
        read_check("R6 read status", 3'd7, 12'h5A3);
        stat_word = 12'h0C9;
        read_check("R6 read status changed", 3'd7, 12'h0C9);
    endtask

    task automatic t_top_addr;
        write_reg(3'd7, 12'h777);
        check_regs("R4 write addr7 ignored");
        read_check("R4 status still read", 3'd7, 12'h0C9);
    endtask

    task automatic t_leading;
        send_frame({12'h0, 12'h7E1, 3'd1, 1'b0, 4'b1011}, 20);
        m_regs[1] = 12'h7E1;
        check_regs("R3 leading bits dropped");
        read_check("R3 read back reg1", 3'd1, 12'h7E1);
    endtask

    task automatic t_short;
        write_reg(3'd5, 12'h3C5);
        send_frame(32'h9E, 8);
        if (m_sr[0] == 1'b0 && m_sr[3:1] != 3'd7) m_regs[m_sr[3:1]] = m_sr[15:4];
        check_regs("R9 short write from held bits");
    endtask

    task automatic t_pin_codes;
        write_reg(3'd3, 12'h2C3);
        check("R7 code 0010", 32'({mfo_oe, mfo_out}), 32'b10);
        write_reg(3'd3, 12'h3C3);
        check("R7 code 0011", 32'({mfo_oe, mfo_out}), 32'b11);
        send_frame(32'({3'd0, 1'b1}), 4);
        check("R8 no readback under 0011", 32'({mfo_oe, mfo_out}), 32'b11);
        for (int k = 0; k < DW; k++) begin
            ser_clk = 1'b1; tick(4); ser_clk = 1'b0; tick(8);
        end
        write_reg(3'd3, 12'h8C3);
        lock_flag = 1'b1; tick(2);
        check("R7 code 1000 lock 1", 32'({mfo_oe, mfo_out}), 32'b11);
        lock_flag = 1'b0; tick(2);
        check("R7 code 1000 lock 0", 32'({mfo_oe, mfo_out}), 32'b10);
        write_reg(3'd3, 12'h0C3);
        check("R7 code 0000 float", 32'({mfo_oe, mfo_out}), 32'b00);
        write_reg(3'd3, 12'h1C3);
        read_check("R8 readback restored", 3'd0, 12'h123);
    endtask

    initial begin
        m_regs[0] = 12'hB88; m_regs[1] = 12'h8B4; m_regs[2] = 12'hEEC;
        m_regs[3] = 12'h400; m_regs[4] = 12'h04B; m_regs[5] = 12'h29B;
        m_regs[6] = 12'hA6C;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_write();
        t_read();
        t_top_addr();
        t_leading();
        t_short();
        t_pin_codes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule